// File: doc/BRIEF.md
# DRAM DLL Re-enable Command Sequencer

This block sits on the controller side of a DDR3-class memory and brings the device back from DLL-off operation to DLL-on operation. During the transition the clock is retuned while the memory holds its contents in self refresh. When a request arrives with the memory quiet, the block puts the device into self refresh and asks the clock generator for the new rate. It waits for the new clock to settle, wakes the device, and writes the mode registers in a fixed order: DLL enable, DLL reset, write latency, then read latency and write recovery. It finishes with a long ZQ calibration.

Every wait is a cycle count taken from an input port, so firmware or a fixed strap can match any speed bin. One shared countdown timer spaces the commands. A second counter measures the DLL lock time from the DLL reset write, and that interval overlaps the later writes and the calibration. The block drives command strobes, mode register select and data, CKE and ODT. It has a request line to the clock generator and returns a flag that tells the rest of the controller when commands that rely on a locked DLL may be sent.

In this list, X' means max(X, 1).

Top module: `dll_relock_seq`

## Requirements
- R1: A start pulse is accepted only when the sequencer is idle, `mem_idle` is high and `odt_req` is low. The self refresh entry command is issued in that same cycle. In every other case start has no effect: no command is issued and busy stays low.
- R2: Every command appears as a one-cycle `cmd_valid` strobe carrying `cmd_code`, encoded as 0 none, 1 self refresh entry, 2 self refresh exit, 3 mode register set, 4 ZQ long calibration. One run issues exactly seven commands, in this order: 1, 2, 3, 3, 3, 3, 4.
- R3: `freq_req` rises exactly t_cksre' cycles after self refresh entry. It stays high up to and including the self refresh exit cycle.
- R4: Self refresh exit is issued in the first cycle in which `clk_stable` has been high for t_cksrx' consecutive cycles. Only cycles after the one in which `freq_req` rose are counted. Any low cycle restarts the count.
- R5: `cke` is low from the self refresh entry cycle through the cycle before self refresh exit, and high in every other cycle.
- R6: The first mode register write comes t_xs' cycles after self refresh exit. It uses `mr_sel`=1, and its data is `mr1_cfg` with bit 0 cleared, which turns the DLL on.
- R7: Three more writes follow, each t_mrd' cycles after the one before. The first uses `mr_sel`=0 with data `mr0_cfg` with bit 8 set (DLL reset). The second uses `mr_sel`=2 with data `mr2_cfg`. The third uses `mr_sel`=0 with data `mr0_cfg` with bit 8 cleared.
- R8: The ZQ long calibration command comes max(t_mrd, t_mod, 1) cycles after the last mode register write.
- R9: `dll_ok` is low from the cycle after acceptance through the cycle before DLL reset write + t_dllk'. It is high from that cycle on.
- R10: `done` is a one-cycle pulse in cycle max(ZQ command + t_zq', DLL reset write + t_dllk'). `busy` is high from the cycle after acceptance through the done cycle, and low otherwise.
- R11: `odt` is held low whenever `busy` is high. While idle it follows `odt_req`.
- R12: During and straight after reset: `busy`, `done`, `cmd_valid` and `freq_req` are low, and `cke` and `dll_ok` are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request to run the re-enable flow |
| mem_idle | input | 1 | All banks precharged, timings met, termination off |
| odt_req | input | 1 | ODT level requested by the controller while idle |
| clk_stable | input | 1 | New clock reported stable by the clock generator |
| t_cksre | input | TW | Self refresh entry to clock change, cycles |
| t_cksrx | input | TW | Required stable clock before exit, cycles |
| t_xs | input | TW | Self refresh exit to first mode write, cycles |
| t_mrd | input | TW | Mode write to mode write, cycles |
| t_mod | input | TW | Mode write to ordinary command, cycles |
| t_dllk | input | TW | DLL lock time after reset write, cycles |
| t_zq | input | TW | ZQ long calibration time, cycles |
| mr0_cfg | input | MRW | New latency/recovery register image (slot 0) |
| mr1_cfg | input | MRW | DLL/drive register image (slot 1) |
| mr2_cfg | input | MRW | Write latency register image (slot 2) |
| cmd_valid | output | 1 | Command strobe |
| cmd_code | output | 3 | Command code |
| mr_sel | output | BAW | Mode register select |
| mr_data | output | MRW | Mode register data |
| cke | output | 1 | Clock enable to the memory |
| odt | output | 1 | On-die termination control |
| freq_req | output | 1 | Request to the clock generator to switch rate |
| dll_ok | output | 1 | Commands needing a locked DLL may be sent |
| busy | output | 1 | Flow in progress |
| done | output | 1 | Flow complete pulse |

## Verification
The hardest behaviour to reach from the ports is the restart of the stable-clock count. It only shows when `clk_stable` drops for a single cycle after a partial run and before the full count is reached. The bench derives `clk_stable` from the cycle in which it saw `freq_req` rise, so a glitch lands at an exact offset inside the count. It also covers the case where the DLL lock time runs past the end of calibration and so sets when done is raised.

// File: rtl/relock_pkg.sv
package relock_pkg;

  typedef enum logic [2:0] {
    CMD_NOP  = 3'd0,
    CMD_SRE  = 3'd1,
    CMD_SRX  = 3'd2,
    CMD_MRS  = 3'd3,
    CMD_ZQCL = 3'd4
  } cmd_e;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_CKSRE,
    ST_FREQ,
    ST_XS,
    ST_MR1,
    ST_RST,
    ST_MR2,
    ST_MOD,
    ST_ZQ
  } state_e;

endpackage

// File: rtl/relock_timer.sv
module relock_timer #(
  parameter int TW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [TW-1:0] val,
  output logic          zero
);

  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt_q <= '0;
    else if (load)         cnt_q <= val;
    else if (cnt_q != '0)  cnt_q <= cnt_q - TW'(1);
  end

  assign zero = (cnt_q == '0);

  // R4: an unloaded, nonzero timer steps down by exactly one
  a_r4_timer_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - TW'(1)));

endmodule

// File: rtl/relock_dll_guard.sv
module relock_dll_guard #(
  parameter int TW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          arm,
  input  logic [TW-1:0] len,
  output logic          ok
);

  logic [TW-1:0] left_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             left_q <= '0;
    else if (arm)           left_q <= len;
    else if (left_q != '0)  left_q <= left_q - TW'(1);
  end

  assign ok = (left_q <= TW'(1));

  // R9: arming with a lock time above one closes the gate next cycle
  a_r9_guard_closed: assert property (@(posedge clk) disable iff (!rst_n)
    (arm && len > TW'(1)) |=> !ok);

endmodule

// File: rtl/relock_fsm.sv
module relock_fsm
  import relock_pkg::*;
#(
  parameter int TW         = 12,
  parameter int MRW        = 16,
  parameter int BAW        = 3,
  parameter int DLLRST_BIT = 8,
  parameter int DLLEN_BIT  = 0
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic           mem_idle,
  input  logic           odt_req,
  input  logic           clk_stable,
  input  logic [TW-1:0]  t_cksre,
  input  logic [TW-1:0]  t_cksrx,
  input  logic [TW-1:0]  t_xs,
  input  logic [TW-1:0]  t_mrd,
  input  logic [TW-1:0]  t_mod,
  input  logic [TW-1:0]  t_zq,
  input  logic [MRW-1:0] mr0_cfg,
  input  logic [MRW-1:0] mr1_cfg,
  input  logic [MRW-1:0] mr2_cfg,
  input  logic           tmr_zero,
  input  logic           lock_ok,
  output logic           tmr_load,
  output logic [TW-1:0]  tmr_val,
  output logic           lock_arm,
  output logic           cmd_valid,
  output logic [2:0]     cmd_code,
  output logic [BAW-1:0] mr_sel,
  output logic [MRW-1:0] mr_data,
  output logic           cke,
  output logic           odt,
  output logic           freq_req,
  output logic           dll_ok,
  output logic           busy,
  output logic           done
);

  localparam logic [MRW-1:0] RST_MASK = {{(MRW-1){1'b0}}, 1'b1} << DLLRST_BIT;
  localparam logic [MRW-1:0] ENA_MASK = {{(MRW-1){1'b0}}, 1'b1} << DLLEN_BIT;

  function automatic logic [TW-1:0] span(input logic [TW-1:0] v);
    return (v == '0) ? '0 : v - TW'(1);
  endfunction

  state_e        st_q, st_d;
  cmd_e          code;
  logic          accept;
  logic          pre_reset;
  logic [TW-1:0] mod_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  assign accept  = (st_q == ST_IDLE) && start && mem_idle && !odt_req;
  assign mod_len = (t_mrd > t_mod) ? t_mrd : t_mod;

  always_comb begin
    st_d      = st_q;
    tmr_load  = 1'b0;
    tmr_val   = '0;
    lock_arm  = 1'b0;
    cmd_valid = 1'b0;
    code      = CMD_NOP;
    mr_sel    = '0;
    mr_data   = '0;
    done      = 1'b0;
    unique case (st_q)
      ST_IDLE: if (accept) begin
        cmd_valid = 1'b1; code = CMD_SRE;
        tmr_load = 1'b1; tmr_val = span(t_cksre);
        st_d = ST_CKSRE;
      end
      ST_CKSRE: if (tmr_zero) begin
        tmr_load = 1'b1; tmr_val = span(t_cksrx);
        st_d = ST_FREQ;
      end
      ST_FREQ: begin
        if (!clk_stable) begin
          tmr_load = 1'b1; tmr_val = span(t_cksrx);
        end else if (tmr_zero) begin
          cmd_valid = 1'b1; code = CMD_SRX;
          tmr_load = 1'b1; tmr_val = span(t_xs);
          st_d = ST_XS;
        end
      end
      ST_XS: if (tmr_zero) begin
        cmd_valid = 1'b1; code = CMD_MRS;
        mr_sel = BAW'(1); mr_data = mr1_cfg & ~ENA_MASK;
        tmr_load = 1'b1; tmr_val = span(t_mrd);
        st_d = ST_MR1;
      end
      ST_MR1: if (tmr_zero) begin
        cmd_valid = 1'b1; code = CMD_MRS;
        mr_sel = BAW'(0); mr_data = mr0_cfg | RST_MASK;
        lock_arm = 1'b1;
        tmr_load = 1'b1; tmr_val = span(t_mrd);
        st_d = ST_RST;
      end
      ST_RST: if (tmr_zero) begin
        cmd_valid = 1'b1; code = CMD_MRS;
        mr_sel = BAW'(2); mr_data = mr2_cfg;
        tmr_load = 1'b1; tmr_val = span(t_mrd);
        st_d = ST_MR2;
      end
      ST_MR2: if (tmr_zero) begin
        cmd_valid = 1'b1; code = CMD_MRS;
        mr_sel = BAW'(0); mr_data = mr0_cfg & ~RST_MASK;
        tmr_load = 1'b1; tmr_val = span(mod_len);
        st_d = ST_MOD;
      end
      ST_MOD: if (tmr_zero) begin
        cmd_valid = 1'b1; code = CMD_ZQCL;
        tmr_load = 1'b1; tmr_val = span(t_zq);
        st_d = ST_ZQ;
      end
      ST_ZQ: if (tmr_zero && lock_ok) begin
        done = 1'b1;
        st_d = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  assign cmd_code  = code;
  assign busy      = (st_q != ST_IDLE);
  assign pre_reset = (st_q == ST_CKSRE) || (st_q == ST_FREQ) ||
                     (st_q == ST_XS)    || (st_q == ST_MR1);
  assign dll_ok    = lock_ok && !pre_reset;
  assign freq_req  = ((st_q == ST_CKSRE) && tmr_zero) || (st_q == ST_FREQ);
  assign cke       = !((code == CMD_SRE) || (st_q == ST_CKSRE) ||
                       ((st_q == ST_FREQ) && (code != CMD_SRX)));
  assign odt       = busy ? 1'b0 : odt_req;

  // R11: termination stays off for the whole flow
  a_r11_odt_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !odt);

  // R10: completion only with a locked DLL
  a_r10_done_locked: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> dll_ok);

  // R10: done is a single pulse followed by idle
  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy));

  // R5: exit is only issued after a cycle with CKE low
  a_r5_cke_before_exit: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_code == 3'd2) |-> !$past(cke));

  // R1: entry starts the flow and drops CKE
  a_r1_entry_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_code == 3'd1) |=> (busy && !cke));

endmodule

// File: rtl/dll_relock_seq.sv
module dll_relock_seq #(
  parameter int TW         = 12,
  parameter int MRW        = 16,
  parameter int BAW        = 3,
  parameter int DLLRST_BIT = 8,
  parameter int DLLEN_BIT  = 0
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic           mem_idle,
  input  logic           odt_req,
  input  logic           clk_stable,
  input  logic [TW-1:0]  t_cksre,
  input  logic [TW-1:0]  t_cksrx,
  input  logic [TW-1:0]  t_xs,
  input  logic [TW-1:0]  t_mrd,
  input  logic [TW-1:0]  t_mod,
  input  logic [TW-1:0]  t_dllk,
  input  logic [TW-1:0]  t_zq,
  input  logic [MRW-1:0] mr0_cfg,
  input  logic [MRW-1:0] mr1_cfg,
  input  logic [MRW-1:0] mr2_cfg,
  output logic           cmd_valid,
  output logic [2:0]     cmd_code,
  output logic [BAW-1:0] mr_sel,
  output logic [MRW-1:0] mr_data,
  output logic           cke,
  output logic           odt,
  output logic           freq_req,
  output logic           dll_ok,
  output logic           busy,
  output logic           done
);

  logic          tmr_load, tmr_zero, lock_arm, lock_ok;
  logic [TW-1:0] tmr_val;

  relock_timer #(.TW(TW)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .val(tmr_val), .zero(tmr_zero)
  );

  relock_dll_guard #(.TW(TW)) u_guard (
    .clk(clk), .rst_n(rst_n), .arm(lock_arm), .len(t_dllk), .ok(lock_ok)
  );

  relock_fsm #(
    .TW(TW), .MRW(MRW), .BAW(BAW),
    .DLLRST_BIT(DLLRST_BIT), .DLLEN_BIT(DLLEN_BIT)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .start(start), .mem_idle(mem_idle),
    .odt_req(odt_req), .clk_stable(clk_stable),
    .t_cksre(t_cksre), .t_cksrx(t_cksrx), .t_xs(t_xs), .t_mrd(t_mrd),
    .t_mod(t_mod), .t_zq(t_zq),
    .mr0_cfg(mr0_cfg), .mr1_cfg(mr1_cfg), .mr2_cfg(mr2_cfg),
    .tmr_zero(tmr_zero), .lock_ok(lock_ok),
    .tmr_load(tmr_load), .tmr_val(tmr_val), .lock_arm(lock_arm),
    .cmd_valid(cmd_valid), .cmd_code(cmd_code), .mr_sel(mr_sel),
    .mr_data(mr_data), .cke(cke), .odt(odt), .freq_req(freq_req),
    .dll_ok(dll_ok), .busy(busy), .done(done)
  );

endmodule

// File: tb/sim_dll_relock_seq.sv
module sim_dll_relock_seq;
  localparam int TW  = 12;
  localparam int MRW = 16;
  localparam int BAW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic start = 0, mem_idle = 0, odt_req = 0, clk_stable = 0;
  logic [TW-1:0] t_cksre = 1, t_cksrx = 1, t_xs = 1, t_mrd = 1, t_mod = 1, t_dllk = 1, t_zq = 1;
  logic [MRW-1:0] mr0_cfg = 0, mr1_cfg = 0, mr2_cfg = 0;
  logic           cmd_valid, cke, odt, freq_req, dll_ok, busy, done;
  logic [2:0]     cmd_code;
  logic [BAW-1:0] mr_sel;
  logic [MRW-1:0] mr_data;

  int n_tests = 0, n_fail = 0, cyc = 0;
  bit finished = 0;

  dll_relock_seq #(.TW(TW), .MRW(MRW), .BAW(BAW)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .mem_idle(mem_idle), .odt_req(odt_req),
    .clk_stable(clk_stable), .t_cksre(t_cksre), .t_cksrx(t_cksrx), .t_xs(t_xs),
    .t_mrd(t_mrd), .t_mod(t_mod), .t_dllk(t_dllk), .t_zq(t_zq),
    .mr0_cfg(mr0_cfg), .mr1_cfg(mr1_cfg), .mr2_cfg(mr2_cfg),
    .cmd_valid(cmd_valid), .cmd_code(cmd_code), .mr_sel(mr_sel), .mr_data(mr_data),
    .cke(cke), .odt(odt), .freq_req(freq_req), .dll_ok(dll_ok), .busy(busy), .done(done)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int mx1(input int v);
    return (v < 1) ? 1 : v;
  endfunction

  // R4 model: first cycle after f whose stable run reaches need
  function automatic int exp_exit(input int f, input int lead, input int glitch, input int need);
    int run = 0;
    for (int t = f + 1; t < f + 10000; t++) begin
      run = ((t - f >= lead) && (t - f != glitch)) ? run + 1 : 0;
      if (run == need) return t;
    end
    return -1;
  endfunction

  task automatic run_case(input int A, input int M, input int X, input int D, input int O,
                          input int Z, input int K, input int L, input int G, input int seed);
    int ev_c[8], ev_k[8], ev_s[8], ev_d[8];
    int nev = 0, a = 0, f = -1, fr_cnt = 0;
    int lo_first = -1, lo_last = -1, lo_cnt = 0, dl_last = -1, dl_cnt = 0;
    int busy_cnt = 0, odt_bad = 0, done_c = -1;
    int srx, e_mr1, e_rst, e_mr2, e_mr0, e_zq, e_done, lockc;
    int exp_k[7] = '{1, 2, 3, 3, 3, 3, 4};
    t_cksre = TW'(A); t_cksrx = TW'(M); t_xs = TW'(X); t_mrd = TW'(D);
    t_mod = TW'(O); t_zq = TW'(Z); t_dllk = TW'(K);
    mr0_cfg = MRW'(16'h1d71 ^ (seed << 2));
    mr1_cfg = MRW'(16'h0045 ^ seed);
    mr2_cfg = MRW'(16'h0018 + seed);
    odt_req = 0; mem_idle = 1;
    for (int n = 0; n < 3000 && done_c < 0; n++) begin
      @(negedge clk);
      cyc++;
      start = (n == 0);
      if (n == 0) a = cyc;
      odt_req = (n > 2);
      clk_stable = (f >= 0) && (cyc - f >= L) && (cyc - f != G);
      #1;
      if (cmd_valid && nev < 8) begin
        ev_c[nev] = cyc; ev_k[nev] = int'(cmd_code);
        ev_s[nev] = int'(mr_sel); ev_d[nev] = int'(mr_data); nev++;
      end
      if (freq_req) begin fr_cnt++; if (f < 0) f = cyc; end
      if (!cke) begin if (lo_first < 0) lo_first = cyc; lo_last = cyc; lo_cnt++; end
      if (!dll_ok) begin dl_last = cyc; dl_cnt++; end
      if (busy) busy_cnt++;
      if (busy && odt) odt_bad++;
      if (done) done_c = cyc;
    end
    if (done_c < 0) chk("R10 run did not finish", 0, 1);
    srx   = exp_exit(a + mx1(A), L, G, mx1(M));
    e_mr1 = srx + mx1(X);
    e_rst = e_mr1 + mx1(D);
    e_mr2 = e_rst + mx1(D);
    e_mr0 = e_mr2 + mx1(D);
    e_zq  = e_mr0 + mx1((D > O) ? D : O);
    lockc = e_rst + mx1(K);
    e_done = (e_zq + mx1(Z) > lockc) ? e_zq + mx1(Z) : lockc;
    chk("R2 command count", nev, 7);
    for (int i = 0; i < 7 && i < nev; i++) chk("R2 command order", ev_k[i], exp_k[i]);
    chk("R1 entry cycle", ev_c[0], a);
    chk("R3 freq_req rise", f, a + mx1(A));
    chk("R3 freq_req length", fr_cnt, srx - (a + mx1(A)) + 1);
    chk("R4 exit cycle", ev_c[1], srx);
    chk("R5 cke low first", lo_first, a);
    chk("R5 cke low last", lo_last, srx - 1);
    chk("R5 cke low count", lo_cnt, srx - a);
    chk("R6 dll enable write cycle", ev_c[2], e_mr1);
    chk("R6 dll enable select", ev_s[2], 1);
    chk("R6 dll enable data", ev_d[2], int'(mr1_cfg & ~16'h0001));
    chk("R7 dll reset write cycle", ev_c[3], e_rst);
    chk("R7 dll reset select", ev_s[3], 0);
    chk("R7 dll reset data", ev_d[3], int'(mr0_cfg | 16'h0100));
    chk("R7 slot2 write cycle", ev_c[4], e_mr2);
    chk("R7 slot2 select", ev_s[4], 2);
    chk("R7 slot2 data", ev_d[4], int'(mr2_cfg));
    chk("R7 final slot0 cycle", ev_c[5], e_mr0);
    chk("R7 final slot0 select", ev_s[5], 0);
    chk("R7 final slot0 data", ev_d[5], int'(mr0_cfg & ~16'h0100));
    chk("R8 calibration cycle", ev_c[6], e_zq);
    chk("R9 dll_ok last low", dl_last, lockc - 1);
    chk("R9 dll_ok low span", dl_cnt, lockc - 1 - a);
    chk("R10 done cycle", done_c, e_done);
    chk("R10 busy span", busy_cnt, e_done - a);
    chk("R11 odt low while busy", odt_bad, 0);
    @(negedge clk); cyc++; #1;
    chk("R10 idle after done", int'(busy), 0);
    chk("R11 odt follows request when idle", int'(odt), 1);
    odt_req = 0; clk_stable = 0;
  endtask

  initial begin
    int av[2] = '{0, 2};
    int mv[2] = '{1, 3};
    int lv[2] = '{0, 5};
    int dv[3] = '{1, 2, 4};
    int ov[2] = '{0, 6};
    int kv[2] = '{3, 40};
    int zv[2] = '{1, 4};
    int seed = 0;
    repeat (3) @(negedge clk);
    #1;
    chk("R12 busy in reset", int'(busy), 0);
    chk("R12 cmd_valid in reset", int'(cmd_valid), 0);
    chk("R12 cke in reset", int'(cke), 1);
    chk("R12 freq_req in reset", int'(freq_req), 0);
    chk("R12 dll_ok in reset", int'(dll_ok), 1);
    chk("R12 done in reset", int'(done), 0);
    @(negedge clk); rst_n = 1;
    // R1: start while memory not idle
    start = 1; mem_idle = 0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); #1;
      chk("R1 ignored when not idle, cmd", int'(cmd_valid), 0);
      chk("R1 ignored when not idle, busy", int'(busy), 0);
    end
    // R1: start while ODT requested
    mem_idle = 1; odt_req = 1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); #1;
      chk("R1 ignored with odt on, cmd", int'(cmd_valid), 0);
      chk("R1 ignored with odt on, busy", int'(busy), 0);
      chk("R11 odt follows request", int'(odt), 1);
    end
    @(negedge clk); start = 0; odt_req = 0;
    foreach (av[ia]) foreach (mv[im]) foreach (lv[il]) foreach (dv[id])
      foreach (ov[io]) foreach (kv[ik]) foreach (zv[iz]) begin
        seed++;
        run_case(av[ia], mv[im], av[ia] + dv[id], dv[id], ov[io], zv[iz], kv[ik],
                 lv[il], -1, seed);
      end
    // R4: glitches on the stable indication restart the count
    run_case(1, 3, 2, 1, 1, 2, 3, 0, 2, 901);
    run_case(2, 2, 1, 2, 3, 1, 5, 1, 3, 902);
    run_case(0, 1, 0, 0, 0, 0, 0, 0, 1, 903);
    run_case(1, 4, 3, 1, 2, 2, 2, 0, 4, 904);
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(4 * 190000);
    if (!finished) begin
      n_fail++;
      n_tests++;
      $display("FAIL R10 watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule